// File: doc/BRIEF.md
# Noise-Tolerant Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. The raw line input enters a single three-flop synchronizer. Every other piece of logic reads only the output of that synchronizer, so no two flops ever sample the raw pin in parallel.

On a falling edge of the synchronized line, the receiver waits half a bit period. It then takes one decision per bit period, so each decision lands near the middle of its bit. Each decision is a two-of-three vote over the synchronized value at that instant and the two values before it.

The receiver starts watching for the next start edge at the middle of the stop bit, not at its end. This gives margin against a transmitter whose clock runs slightly fast.

The state register uses explicit binary codes. Any code outside the legal set returns the machine to idle on the next clock. Two debug strobes are provided: one marks each bit decision, and one marks each return to start-edge hunting. The bit period is derived from the clock and baud-rate parameters.

Top module: `serial_rx_voter`

## Requirements
- R1: After a synchronous reset, `rx_byte` is 0x00 and `rx_valid`, `frame_err`, `sample_tick` and `rearm_tick` are all low.
- R2: A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. For such a frame, `rx_valid` is high for exactly one cycle and `rx_byte` then holds the received byte until the next valid frame.
- R3: `sample_tick` pulses once per bit decision. The first decision comes half a bit period after the start edge, and later ones follow every bit period. A complete frame therefore gives exactly 10 pulses, and the stop-bit decision coincides with any `rx_valid` or `frame_err` pulse.
- R4: Each bit decision is a majority of three consecutive synchronized samples. A line glitch of one clock cycle or less at a bit centre does not change the received byte.
- R5: If the start bit is voted high at its centre, the frame is dropped. In that case `rearm_tick` pulses, and neither `rx_valid` nor `frame_err` is raised.
- R6: If the stop bit is voted low, `frame_err` pulses for one cycle and `rx_valid` stays low.
- R7: `rearm_tick` pulses for one cycle at the stop-bit decision, which is the middle of the stop bit. Back-to-back frames with a single stop bit are therefore all received.
- R8: Frames whose bit period differs from nominal by plus or minus 2% are received without error.
- R9: If the state register holds any code other than the four legal ones (idle 0, start 1, data 2, stop 3), the next clock sets it to idle and pulses `rearm_tick`.
- R10: A line that is still low when hunting resumes does not start a frame. A new frame needs a high-to-low transition of the synchronized line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_pin | input | 1 | Raw asynchronous serial line, idle high |
| rx_byte | output | 8 | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` was updated |
| frame_err | output | 1 | One-cycle strobe: stop bit was voted low |
| sample_tick | output | 1 | Debug strobe at every bit decision |
| rearm_tick | output | 1 | Debug strobe when hunting for a start edge resumes |

## Verification
The recovery from an illegal state code cannot be reached from the pins at all, because the legal transitions never produce such a code. The bench therefore overrides the state register with an unused code for less than one clock while the receiver is idle. It then expects a `rearm_tick` pulse at the ports and a correctly received byte right after.

The other hard cases are timing corners, reached by driving the line with real-valued delays:
- back-to-back frames from a transmitter 2% fast, so the next start edge arrives just after the middle of the stop bit;
- sub-cycle pulses placed at a bit centre;
- a start pulse shorter than half a bit.

// File: rtl/serial_rx_voter.sv
module serial_rx_voter #(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 9600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_pin,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       frame_err,
  output logic       sample_tick,
  output logic       rearm_tick
);
  localparam int BIT_CYC = CLK_HZ / BAUD;
  localparam int HALF    = BIT_CYC / 2;
  localparam int CW      = $clog2(BIT_CYC + 1);

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_START = 3'd1;
  localparam logic [2:0] ST_DATA  = 3'd2;
  localparam logic [2:0] ST_STOP  = 3'd3;

  logic [2:0]    sync_q;
  logic [1:0]    hist_q;
  logic [2:0]    state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    shift_q;

  wire rxs    = sync_q[2];
  wire vote   = (rxs & hist_q[0]) | (rxs & hist_q[1]) | (hist_q[0] & hist_q[1]);
  wire fall   = hist_q[0] & ~rxs;
  wire tick   = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= 3'b111;
      hist_q      <= 2'b11;
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      shift_q     <= '0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      frame_err   <= 1'b0;
      sample_tick <= 1'b0;
      rearm_tick  <= 1'b0;
    end else begin
      sync_q      <= {sync_q[1:0], rx_pin};
      hist_q      <= {hist_q[0], rxs};
      rx_valid    <= 1'b0;
      frame_err   <= 1'b0;
      sample_tick <= 1'b0;
      rearm_tick  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fall) begin
            state_q <= ST_START;
            cnt_q   <= CW'(HALF);
          end
        end
        ST_START: begin
          if (tick) begin
            sample_tick <= 1'b1;
            if (vote) begin
              state_q    <= ST_IDLE;
              rearm_tick <= 1'b1;
            end else begin
              state_q <= ST_DATA;
              cnt_q   <= CW'(BIT_CYC - 1);
              bit_q   <= '0;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_DATA: begin
          if (tick) begin
            sample_tick <= 1'b1;
            shift_q     <= {vote, shift_q[7:1]};
            bit_q       <= bit_q + 1'b1;
            cnt_q       <= CW'(BIT_CYC - 1);
            if (bit_q == 3'd7) state_q <= ST_STOP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_STOP: begin
          if (tick) begin
            sample_tick <= 1'b1;
            rearm_tick  <= 1'b1;
            state_q     <= ST_IDLE;
            if (vote) begin
              rx_valid <= 1'b1;
              rx_byte  <= shift_q;
            end else begin
              frame_err <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          state_q    <= ST_IDLE;
          rearm_tick <= 1'b1;
        end
      endcase
    end
  end
endmodule

module serial_rx_voter_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_q,
  input logic       rx_valid,
  input logic       frame_err,
  input logic       sample_tick,
  input logic       rearm_tick
);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_result_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid || frame_err) |-> (sample_tick && rearm_tick));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && frame_err));

  assert_rearm_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rearm_tick |=> !rearm_tick);

  assert_illegal_recover_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q > 3'd3) |=> (state_q == 3'd0 && rearm_tick));
endmodule

bind serial_rx_voter serial_rx_voter_chk u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .rx_valid(rx_valid),
  .frame_err(frame_err), .sample_tick(sample_tick), .rearm_tick(rearm_tick)
);

// File: tb/serial_rx_voter_bench.sv
`timescale 1ns/1ps
module serial_rx_voter_bench;
  localparam real NOM_NS = 64.0 * 4.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_pin = 1'b1;
  logic [7:0] rx_byte;
  logic       rx_valid, frame_err, sample_tick, rearm_tick;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [8:0] expq[$];
  int  samp_cnt = 0;
  bit  rearm_seen = 0;
  bit  prev_valid = 0;

  always #2 clk = ~clk;

  serial_rx_voter #(.CLK_HZ(6400), .BAUD(100)) u_serial_rx_voter (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .frame_err(frame_err),
    .sample_tick(sample_tick), .rearm_tick(rearm_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (sample_tick) samp_cnt++;
      if (rearm_tick) rearm_seen = 1;
      if (rx_valid && prev_valid) check(0, "R2 valid longer than one cycle", 1, 0);
      if (rx_valid || frame_err) begin
        if (expq.size() == 0) begin
          check(0, "R5/R10 unexpected output", {frame_err, rx_byte}, 0);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          if (e[8]) check(frame_err && !rx_valid, "R6 framing error", {frame_err, rx_valid}, 2);
          else check(rx_valid && rx_byte == e[7:0], "R2/R8 byte", {frame_err, rx_byte}, e);
        end
      end
      prev_valid = rx_valid;
    end
  end

  task automatic drive_bit(input bit v, input real bt, input bit glitch);
    if (glitch) begin
      rx_pin = v; #(bt/2.0 - 1.5);
      rx_pin = ~v; #3.0;
      rx_pin = v; #(bt/2.0 - 1.5);
    end else begin
      rx_pin = v; #(bt);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit stop, input real skew, input int gbit);
    real bt;
    bt = NOM_NS * (1.0 + skew);
    expq.push_back({~stop, b});
    samp_cnt = 0;
    drive_bit(1'b0, bt, gbit == 0);
    for (int i = 0; i < 8; i++) drive_bit(b[i], bt, gbit == i + 1);
    rearm_seen = 0;
    drive_bit(stop, bt, 1'b0);
    check(rearm_seen, "R7 rearm before stop end", rearm_seen, 1);
    check(samp_cnt == 10, "R3 sample count", samp_cnt, 10);
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check(rx_byte == 8'h00 && !rx_valid && !frame_err && !sample_tick && !rearm_tick,
          "R1 reset state", {rx_valid, frame_err, sample_tick, rearm_tick, rx_byte}, 0);
    #(NOM_NS * 2.0);

    send(8'hA5, 1'b1, 0.0, -1);
    send(8'h3C, 1'b1, 0.0, -1);
    // R7 R8: back-to-back, fast transmitter
    send(8'h01, 1'b1, -0.02, -1);
    send(8'h80, 1'b1, -0.02, -1);
    send(8'hFF, 1'b1, -0.02, -1);
    send(8'h00, 1'b1, -0.02, -1);
    // R8: slow transmitter
    send(8'h5A, 1'b1, 0.02, -1);
    send(8'hC3, 1'b1, 0.02, -1);
    // R4: short pulses at bit centres
    send(8'h96, 1'b1, 0.0, 3);
    send(8'h69, 1'b1, 0.0, 8);
    #(NOM_NS * 2.0);

    // R5: start pulse far shorter than half a bit
    samp_cnt = 0; rearm_seen = 0;
    rx_pin = 1'b0; #12; rx_pin = 1'b1;
    #(NOM_NS * 2.0);
    check(rearm_seen, "R5 rearm after false start", rearm_seen, 1);
    check(samp_cnt == 1, "R5 single decision", samp_cnt, 1);

    // R6 then R10: stop low, line stays low
    send(8'h77, 1'b0, 0.0, -1);
    samp_cnt = 0;
    rx_pin = 1'b0; #(NOM_NS * 3.0);
    check(samp_cnt == 0, "R10 low line starts nothing", samp_cnt, 0);
    rx_pin = 1'b1; #(NOM_NS * 2.0);
    send(8'h5C, 1'b1, 0.0, -1);
    #(NOM_NS * 2.0);

    // R9: illegal state code
    @(negedge clk);
    rearm_seen = 0;
    force u_serial_rx_voter.state_q = 3'b101;
    #1 release u_serial_rx_voter.state_q;
    repeat (3) @(negedge clk);
    check(rearm_seen, "R9 recovery rearm", rearm_seen, 1);
    send(8'h42, 1'b1, 0.0, -1);
    #(NOM_NS * 2.0);

    check(expq.size() == 0, "R2 all expected results seen", expq.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule